// File: doc/BRIEF.md
# Double-Precision to Integer Converter with Saturating and Wrapping Modes

This unit takes a 64-bit IEEE-754 double-precision operand and turns it into an integer. A two-bit target code selects the integer format: signed or unsigned, 32 or 64 bits wide. Fractional bits are always discarded, so the result is rounded toward zero. The result is registered, and it appears one clock after the operand is presented with `in_valid` high.

Out-of-range inputs are handled in one of two ways. In saturating mode, an input outside the target range is clamped to the nearer limit, and a NaN input gives the range minimum. Both cases raise the invalid-conversion flag. In wrapping mode, the truncated integer is reduced modulo 2^64. For the two 32-bit targets, the upper half of the result is then forced to zero.

The unit reports three status flags: signaling NaN, invalid conversion, and inexact. It also reports an invalid summary of the first two. A write strobe tells the destination whether to take the result. The strobe is withheld when the invalid trap is enabled and the invalid summary is set. An overflow indication and a five-bit result-class field are also driven, and both read zero for every conversion.

Top module: `dbl_to_int_cvt`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every output is zero.
- R2: A request accepted at a rising edge with `in_valid` high shows its results with `out_valid` high after that edge. A cycle without a request drives `out_valid`, `out_value`, `out_write` and every flag to zero after the next edge.
- R3: Rounding is toward zero. The target codes are: 0 for signed 32-bit, 1 for unsigned 32-bit, 2 for signed 64-bit and 3 for unsigned 64-bit. In saturating mode (`in_wrap`=0), an in-range value is returned as a 64-bit two's-complement integer. A signed 32-bit result is therefore sign-extended.
- R4: In saturating mode, a finite or infinite value outside the target range clamps to the nearer limit and sets `out_badcvt`. The limits are:
  - code 0: 0xFFFFFFFF80000000 and 0x7FFFFFFF
  - code 1: 0 and 0xFFFFFFFF
  - code 2: 0x8000000000000000 and 0x7FFFFFFFFFFFFFFF
  - code 3: 0 and 0xFFFFFFFFFFFFFFFF
- R5: In saturating mode, any NaN returns the range minimum of the target and sets `out_badcvt`. A NaN whose fraction MSB (operand bit 51) is zero is signaling and also sets `out_snan`.
- R6: In wrapping mode (`in_wrap`=1), a finite value returns its truncated integer modulo 2^64 in two's complement. For targets 0 and 1, bits 63:32 are then cleared, and no range flag is raised. An infinity or NaN returns 0 and sets `out_badcvt`.
- R7: `out_inexact` is set exactly when the operand is finite, `out_badcvt` is clear, and nonzero fraction bits were discarded. Both signs of zero convert exactly to 0.
- R8: `out_invalid` equals `out_snan` OR `out_badcvt` on every result.
- R9: `out_write` is high on a result unless the request carried `in_trap_en`=1 and its `out_invalid` is set. When the write is withheld, `out_value` still shows the converted value.
- R10: On every result, `out_overflow` is 0 and `out_class` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are presented this cycle |
| in_operand | input | 64 | Double-precision operand |
| in_target | input | 2 | Integer format: 0 s32, 1 u32, 2 s64, 3 u64 |
| in_wrap | input | 1 | 1 = modular wrapping, 0 = saturation |
| in_trap_en | input | 1 | Invalid-exception enable, gates the write |
| out_valid | output | 1 | Result registers hold a conversion |
| out_value | output | 64 | Integer result |
| out_write | output | 1 | Destination write strobe |
| out_invalid | output | 1 | Invalid summary flag |
| out_snan | output | 1 | Operand was a signaling NaN |
| out_badcvt | output | 1 | Invalid conversion (NaN, infinity or out of range) |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_overflow | output | 1 | Overflow indication, always cleared |
| out_class | output | 5 | Result-class field, always zero |

## Verification
The checker relies on two assumptions about the inputs:
- `in_valid`, `in_trap_en`, `in_wrap` and `in_target` are stable around each rising edge.
- `in_valid` is held low while reset is asserted, so the one-cycle latency and write-gating properties compare against the previous cycle's request only after a cycle out of reset.

All four target codes are legal, so no encoding is excluded. The bench changes inputs only on falling edges and never raises `in_valid` during reset, which keeps every request inside these assumptions.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int F2I_EXP_W    = 11;
    localparam int F2I_FRAC_W   = 52;
    localparam int F2I_INT_W    = 64;
    localparam int F2I_NARROW_W = 32;
    localparam int F2I_CLS_W    = 5;
    localparam int F2I_NTGT     = 4;

    // bit 0 = unsigned, bit 1 = 64-bit wide
    typedef enum logic [1:0] {
        TGT_S32 = 2'd0,
        TGT_U32 = 2'd1,
        TGT_S64 = 2'd2,
        TGT_U64 = 2'd3
    } tgt_e;

    // decoded operand: magnitude of the truncated value (mod 2^INT_W)
    typedef struct packed {
        logic                 sign;
        logic                 is_nan;
        logic                 is_snan;
        logic                 is_inf;
        logic                 huge;      // |value| >= 2^INT_W
        logic                 frac_lost;
        logic [F2I_INT_W-1:0] mag;
    } unpk_t;

    // registered result set
    typedef struct packed {
        logic                 valid;
        logic [F2I_INT_W-1:0] value;
        logic                 write;
        logic                 invalid;
        logic                 snan;
        logic                 badcvt;
        logic                 inexact;
        logic                 ovf;
        logic [F2I_CLS_W-1:0] cls;
    } res_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_W  = F2I_EXP_W,
    parameter int FRAC_W = F2I_FRAC_W,
    parameter int INT_W  = F2I_INT_W
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output unpk_t                 fields
);
    localparam int EW = EXP_W + 2;
    localparam logic signed [EW-1:0] BIAS_S = EW'((1 << (EXP_W - 1)) - 1);
    localparam logic signed [EW-1:0] FRAC_S = EW'(FRAC_W);
    localparam logic signed [EW-1:0] INT_S  = EW'(INT_W);
    localparam logic [INT_W-1:0]     ONE    = INT_W'(1);

    logic                    sign_bit;
    logic [EXP_W-1:0]        exp_f;
    logic [FRAC_W-1:0]       frac_f;
    logic [INT_W-1:0]        mant_ext;
    logic signed [EW-1:0]    e_unb;
    logic signed [EW-1:0]    rsh;
    logic signed [EW-1:0]    lsh;
    logic [INT_W-1:0]        low_mask;

    assign sign_bit = operand[EXP_W+FRAC_W];
    assign exp_f    = operand[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_f   = operand[FRAC_W-1:0];
    assign mant_ext = INT_W'({1'b1, frac_f});
    assign e_unb    = $signed({2'b00, exp_f}) - BIAS_S;
    assign rsh      = FRAC_S - e_unb;
    assign lsh      = e_unb - FRAC_S;

    always_comb begin
        fields      = '0;
        low_mask    = '0;
        fields.sign = sign_bit;
        if (&exp_f) begin
            if (|frac_f) begin
                fields.is_nan  = 1'b1;
                fields.is_snan = ~frac_f[FRAC_W-1];
            end else begin
                fields.is_inf  = 1'b1;
            end
        end else if (exp_f == '0) begin
            // zero or subnormal: truncates to 0
            fields.frac_lost = |frac_f;
        end else if (e_unb[EW-1]) begin
            // 0 < |x| < 1
            fields.frac_lost = 1'b1;
        end else if (e_unb < FRAC_S) begin
            low_mask         = (ONE << rsh) - ONE;
            fields.mag       = mant_ext >> rsh;
            fields.frac_lost = |(mant_ext & low_mask);
        end else begin
            fields.huge = (e_unb >= INT_S);
            if (lsh < INT_S) begin
                fields.mag = mant_ext << lsh;
            end
        end
    end

endmodule

// File: rtl/f2i_range.sv
module f2i_range
    import f2i_pkg::*;
#(
    parameter int INT_W    = F2I_INT_W,
    parameter int NARROW_W = F2I_NARROW_W,
    parameter int NTGT     = F2I_NTGT
) (
    input  unpk_t             fields,
    input  tgt_e              target,
    output logic              in_range,
    output logic [INT_W-1:0]  lim_lo,
    output logic [INT_W-1:0]  lim_hi
);
    logic [INT_W-1:0] pos_max [NTGT];
    logic [INT_W-1:0] neg_max [NTGT];
    logic [INT_W-1:0] lo_lim  [NTGT];

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        localparam int W    = (t >= NTGT / 2) ? INT_W : NARROW_W;
        localparam bit SG   = (t % 2) == 0;
        localparam int DROP = INT_W - W + (SG ? 1 : 0);
        assign pos_max[t] = {INT_W{1'b1}} >> DROP;
        assign neg_max[t] = SG ? (INT_W'(1) << (W - 1)) : '0;
        assign lo_lim[t]  = SG ? ~pos_max[t] : '0;
    end

    always_comb begin
        if (fields.is_nan || fields.is_inf || fields.huge) begin
            in_range = 1'b0;
        end else if (fields.sign) begin
            in_range = (fields.mag <= neg_max[target]);
        end else begin
            in_range = (fields.mag <= pos_max[target]);
        end
        lim_lo = lo_lim[target];
        lim_hi = pos_max[target];
    end

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
    import f2i_pkg::*;
#(
    parameter int INT_W    = F2I_INT_W,
    parameter int NARROW_W = F2I_NARROW_W
) (
    input  unpk_t             fields,
    input  tgt_e              target,
    input  logic              wrap,
    input  logic              in_range,
    input  logic [INT_W-1:0]  lim_lo,
    input  logic [INT_W-1:0]  lim_hi,
    output logic [INT_W-1:0]  value,
    output logic              snan,
    output logic              badcvt,
    output logic              inexact
);
    localparam logic [INT_W-1:0] NARROW_MASK = {{(INT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [INT_W-1:0] signed_mag;

    assign signed_mag = fields.sign ? (~fields.mag + INT_W'(1)) : fields.mag;

    always_comb begin
        value  = '0;
        badcvt = 1'b0;
        if (wrap) begin
            if (fields.is_nan || fields.is_inf) begin
                badcvt = 1'b1;
            end else if (target[1]) begin
                value = signed_mag;
            end else begin
                value = signed_mag & NARROW_MASK;
            end
        end else begin
            if (fields.is_nan) begin
                badcvt = 1'b1;
                value  = lim_lo;
            end else if (!in_range) begin
                badcvt = 1'b1;
                value  = fields.sign ? lim_lo : lim_hi;
            end else begin
                value  = signed_mag;
            end
        end
        snan    = fields.is_snan;
        inexact = fields.frac_lost & ~badcvt;
    end

endmodule

// File: rtl/dbl_to_int_cvt.sv
module dbl_to_int_cvt
    import f2i_pkg::*;
#(
    parameter int EXP_W    = F2I_EXP_W,
    parameter int FRAC_W   = F2I_FRAC_W,
    parameter int INT_W    = F2I_INT_W,
    parameter int NARROW_W = F2I_NARROW_W,
    parameter int CLS_W    = F2I_CLS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   in_operand,
    input  logic [1:0]              in_target,
    input  logic                    in_wrap,
    input  logic                    in_trap_en,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_value,
    output logic                    out_write,
    output logic                    out_invalid,
    output logic                    out_snan,
    output logic                    out_badcvt,
    output logic                    out_inexact,
    output logic                    out_overflow,
    output logic [CLS_W-1:0]        out_class
);
    unpk_t            fields;
    tgt_e             target;
    logic             in_range;
    logic [INT_W-1:0] lim_lo;
    logic [INT_W-1:0] lim_hi;
    logic [INT_W-1:0] pk_value;
    logic             pk_snan;
    logic             pk_badcvt;
    logic             pk_inexact;
    res_t             res_d;
    res_t             res_q;

    assign target = tgt_e'(in_target);

    f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_unpack (
        .operand (in_operand),
        .fields  (fields)
    );

    f2i_range #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_range (
        .fields   (fields),
        .target   (target),
        .in_range (in_range),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi)
    );

    f2i_pack #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_pack (
        .fields   (fields),
        .target   (target),
        .wrap     (in_wrap),
        .in_range (in_range),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .value    (pk_value),
        .snan     (pk_snan),
        .badcvt   (pk_badcvt),
        .inexact  (pk_inexact)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid   = 1'b1;
            res_d.value   = pk_value;
            res_d.snan    = pk_snan;
            res_d.badcvt  = pk_badcvt;
            res_d.invalid = pk_snan | pk_badcvt;
            res_d.inexact = pk_inexact;
            res_d.write   = ~(in_trap_en & (pk_snan | pk_badcvt));
            res_d.ovf     = 1'b0;
            res_d.cls     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_value    = res_q.value;
    assign out_write    = res_q.write;
    assign out_invalid  = res_q.invalid;
    assign out_snan     = res_q.snan;
    assign out_badcvt   = res_q.badcvt;
    assign out_inexact  = res_q.inexact;
    assign out_overflow = res_q.ovf;
    assign out_class    = res_q.cls;

endmodule

// File: rtl/f2i_checker.sv
module f2i_checker #(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32,
    parameter int CLS_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_target,
    input logic              in_wrap,
    input logic              in_trap_en,
    input logic              out_valid,
    input logic [INT_W-1:0]  out_value,
    input logic              out_write,
    input logic              out_invalid,
    input logic              out_snan,
    input logic              out_badcvt,
    input logic              out_inexact,
    input logic              out_overflow,
    input logic [CLS_W-1:0]  out_class
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_value == '0 && !out_write && !out_invalid && !out_inexact));

    p_snan_is_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_snan |-> out_badcvt);

    p_narrow_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && $past(in_wrap) && !$past(in_target[1]))
        |-> (out_value[INT_W-1:NARROW_W] == '0));

    p_inexact_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_inexact |-> !out_invalid);

    p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> (out_write == !($past(in_trap_en) && out_invalid)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_overflow && out_class == '0));

endmodule

bind dbl_to_int_cvt f2i_checker #(.INT_W(INT_W), .NARROW_W(NARROW_W), .CLS_W(CLS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_target    (in_target),
    .in_wrap      (in_wrap),
    .in_trap_en   (in_trap_en),
    .out_valid    (out_valid),
    .out_value    (out_value),
    .out_write    (out_write),
    .out_invalid  (out_invalid),
    .out_snan     (out_snan),
    .out_badcvt   (out_badcvt),
    .out_inexact  (out_inexact),
    .out_overflow (out_overflow),
    .out_class    (out_class)
);

// File: tb/tb_dbl_to_int_cvt.sv
module tb_dbl_to_int_cvt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_target = '0;
    logic        in_wrap = 1'b0;
    logic        in_trap_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_write;
    logic        out_invalid;
    logic        out_snan;
    logic        out_badcvt;
    logic        out_inexact;
    logic        out_overflow;
    logic [4:0]  out_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbl_to_int_cvt dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_target(in_target), .in_wrap(in_wrap), .in_trap_en(in_trap_en),
        .out_valid(out_valid), .out_value(out_value), .out_write(out_write),
        .out_invalid(out_invalid), .out_snan(out_snan), .out_badcvt(out_badcvt),
        .out_inexact(out_inexact), .out_overflow(out_overflow), .out_class(out_class)
    );

    // {operand, target, wrap, trap, value, {snan,badcvt,inexact,write}, req}
    localparam int NV = 36;
    localparam logic [139:0] VEC [NV] = '{
        {64'h3FF0000000000000, 2'd0, 1'b0, 1'b0, 64'h0000000000000001, 4'b0001, 4'd3},  // R3 1.0
        {64'h4004000000000000, 2'd0, 1'b0, 1'b0, 64'h0000000000000002, 4'b0011, 4'd7},  // R7 2.5
        {64'hC004000000000000, 2'd0, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFE, 4'b0011, 4'd3},  // R3 -2.5
        {64'h3FE0000000000000, 2'd1, 1'b0, 1'b0, 64'h0000000000000000, 4'b0011, 4'd7},  // R7 0.5
        {64'hBFE0000000000000, 2'd1, 1'b0, 1'b0, 64'h0000000000000000, 4'b0011, 4'd7},  // R7 -0.5 u32
        {64'h8000000000000000, 2'd2, 1'b0, 1'b0, 64'h0000000000000000, 4'b0001, 4'd7},  // R7 -0
        {64'h0000000000000001, 2'd3, 1'b0, 1'b0, 64'h0000000000000000, 4'b0011, 4'd7},  // R7 subnormal
        {64'h41DFFFFFFFC00000, 2'd0, 1'b0, 1'b0, 64'h000000007FFFFFFF, 4'b0001, 4'd3},  // R3 2^31-1
        {64'h41E0000000000000, 2'd0, 1'b0, 1'b0, 64'h000000007FFFFFFF, 4'b0101, 4'd4},  // R4 2^31
        {64'hC1E0000000000000, 2'd0, 1'b0, 1'b0, 64'hFFFFFFFF80000000, 4'b0001, 4'd3},  // R3 -2^31
        {64'hC1E0000000200000, 2'd0, 1'b0, 1'b0, 64'hFFFFFFFF80000000, 4'b0101, 4'd4},  // R4 -2^31-1
        {64'h41EFFFFFFFE00000, 2'd1, 1'b0, 1'b0, 64'h00000000FFFFFFFF, 4'b0001, 4'd3},  // R3 2^32-1
        {64'h41F0000000000000, 2'd1, 1'b0, 1'b0, 64'h00000000FFFFFFFF, 4'b0101, 4'd4},  // R4 2^32
        {64'hBFF0000000000000, 2'd1, 1'b0, 1'b0, 64'h0000000000000000, 4'b0101, 4'd4},  // R4 -1 u32
        {64'h43E0000000000000, 2'd2, 1'b0, 1'b0, 64'h7FFFFFFFFFFFFFFF, 4'b0101, 4'd4},  // R4 2^63 s64
        {64'hC3E0000000000000, 2'd2, 1'b0, 1'b0, 64'h8000000000000000, 4'b0001, 4'd3},  // R3 -2^63
        {64'h43E0000000000000, 2'd3, 1'b0, 1'b0, 64'h8000000000000000, 4'b0001, 4'd3},  // R3 2^63 u64
        {64'h43EFFFFFFFFFFFFF, 2'd3, 1'b0, 1'b0, 64'hFFFFFFFFFFFFF800, 4'b0001, 4'd3},  // R3 below 2^64
        {64'h43F0000000000000, 2'd3, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 4'b0101, 4'd4},  // R4 2^64
        {64'h7FF0000000000000, 2'd0, 1'b0, 1'b0, 64'h000000007FFFFFFF, 4'b0101, 4'd4},  // R4 +inf
        {64'hFFF0000000000000, 2'd2, 1'b0, 1'b0, 64'h8000000000000000, 4'b0101, 4'd4},  // R4 -inf s64
        {64'hFFF0000000000000, 2'd3, 1'b0, 1'b0, 64'h0000000000000000, 4'b0101, 4'd4},  // R4 -inf u64
        {64'h7FF8000000000000, 2'd0, 1'b0, 1'b0, 64'hFFFFFFFF80000000, 4'b0101, 4'd5},  // R5 qNaN
        {64'h7FF0000000000001, 2'd1, 1'b0, 1'b0, 64'h0000000000000000, 4'b1101, 4'd5},  // R5 sNaN
        {64'h7FF0000000000001, 2'd2, 1'b0, 1'b1, 64'h8000000000000000, 4'b1100, 4'd9},  // R9 sNaN trap
        {64'h7FF8000000000000, 2'd3, 1'b0, 1'b1, 64'h0000000000000000, 4'b0100, 4'd9},  // R9 qNaN trap
        {64'h3FF8000000000000, 2'd2, 1'b0, 1'b1, 64'h0000000000000001, 4'b0011, 4'd9},  // R9 valid trap
        {64'h41F0000000500000, 2'd1, 1'b1, 1'b0, 64'h0000000000000005, 4'b0001, 4'd6},  // R6 2^32+5
        {64'hBFF0000000000000, 2'd0, 1'b1, 1'b0, 64'h00000000FFFFFFFF, 4'b0001, 4'd6},  // R6 -1 s32
        {64'h43F0000000000000, 2'd2, 1'b1, 1'b0, 64'h0000000000000000, 4'b0001, 4'd6},  // R6 2^64
        {64'h43E0000000000000, 2'd2, 1'b1, 1'b0, 64'h8000000000000000, 4'b0001, 4'd6},  // R6 2^63
        {64'hC004000000000000, 2'd2, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFE, 4'b0011, 4'd6},  // R6 -2.5
        {64'h7FF0000000000000, 2'd3, 1'b1, 1'b0, 64'h0000000000000000, 4'b0101, 4'd6},  // R6 +inf
        {64'h7FF0000000000001, 2'd0, 1'b1, 1'b1, 64'h0000000000000000, 4'b1100, 4'd6},  // R6 sNaN trap
        {64'h4730000000000000, 2'd2, 1'b1, 1'b0, 64'h0000000000000000, 4'b0001, 4'd6},  // R6 2^116
        {64'hC1E0000000200000, 2'd1, 1'b1, 1'b0, 64'h000000007FFFFFFF, 4'b0001, 4'd6}   // R6 -2^31-1
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic all_zero(input string tag);
        check(tag, {out_valid, out_write, out_invalid, out_snan, out_badcvt,
                    out_inexact, out_overflow, out_class}, '0);
        check(tag, out_value, '0);
    endtask

    task automatic drive(input logic [63:0] op, input logic [1:0] tg, input logic wr, input logic tr);
        in_operand = op;
        in_target  = tg;
        in_wrap    = wr;
        in_trap_en = tr;
        in_valid   = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: held in reset
        repeat (3) @(negedge clk);
        all_zero("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        all_zero("R1 after release");

        // table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [139:0] v;
            logic [3:0]   fl;
            string        tag;
            v  = VEC[i];
            fl = v[7:4];
            tag = $sformatf("R%0d vec %0d", v[3:0], i);
            @(negedge clk);
            drive(v[139:76], v[75:74], v[73], v[72]);
            @(negedge clk);
            in_valid = 1'b0;
            check({tag, " valid R2"}, {63'd0, out_valid}, 64'd1);
            check({tag, " value"}, out_value, v[71:8]);
            check({tag, " flags"}, {60'd0, out_snan, out_badcvt, out_inexact, out_write}, {60'd0, fl});
            check({tag, " invalid R8"}, {63'd0, out_invalid}, {63'd0, fl[3] | fl[2]});
            check({tag, " ovf/class R10"}, {58'd0, out_overflow, out_class}, '0);
        end

        // R2: back-to-back requests, then an idle cycle
        @(negedge clk);
        drive(64'h4004000000000000, 2'd2, 1'b0, 1'b0);   // 2.5 -> 2
        @(negedge clk);
        check("R2 first of pair", out_value, 64'd2);
        drive(64'hC014000000000000, 2'd2, 1'b0, 1'b0);   // -5.0 -> -5
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second of pair", out_value, 64'hFFFFFFFFFFFFFFFB);
        check("R2 second valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        all_zero("R2 idle cycle");

        // R9: value visible while write withheld (trap on, out of range)
        drive(64'h41F0000000000000, 2'd0, 1'b0, 1'b1);   // 2^32 s32
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 gated write", {63'd0, out_write}, 64'd0);
        check("R9 value kept", out_value, 64'h000000007FFFFFFF);

        // R1: reset mid-stream clears a held result
        drive(64'h3FF0000000000000, 2'd3, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 pre-reset value", out_value, 64'd1);
        rst_n = 1'b0;
        #1;
        all_zero("R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        all_zero("R1 after second release");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule